// File: doc/BRIEF.md
# Bunch-Train Hit Memory with Serial Drain

This block captures the binary hit pattern of a 64-channel front end over a bunch train. Every channel delivers a 2-bit code formed by two discriminator thresholds. On each bunch-crossing strobe during acquisition, the block checks whether any channel code is non-zero. If one is, it stores a whole-chip event: the 24-bit crossing number followed by all 128 code bits. Crossings with no hit are skipped, which gives zero suppression. They still advance the crossing counter.

After the train, a readout request drains the memory over a single serial line. The frame starts with an 8-bit header, which is the value on `chip_id`. The stored events follow, oldest first. The bit period is chosen at request time: a slow divider (default 50 clocks per bit) or a fast divider (default 10 clocks per bit). At 50 MHz these give the 1 MHz and 5 MHz rates. An end-of-readout pulse closes the frame and empties the memory. A full flag warns that the 128-event capacity has been reached.

The control state machine has five states:
- `ST_IDLE`: goes to `ST_ACQ` on `acq_start`; otherwise goes to `ST_HDR` on `rd_req`.
- `ST_ACQ`: goes back to `ST_IDLE` on `acq_stop`.
- `ST_HDR`: after the last header bit, goes to `ST_EVT` if events are stored, else to `ST_DONE`.
- `ST_EVT`: after the last bit of an event, stays in `ST_EVT` for the next event, or goes to `ST_DONE` after the newest one.
- `ST_DONE`: always returns to `ST_IDLE` after one cycle.

Top module: `hit_train_mem`

## Requirements
- R1: After reset, `ser_out`, `mem_full` and `rd_done` are 0 and the memory is empty.
- R2: An event is written only on a `bx_strobe` cycle in acquisition where at least one 2-bit code in `hit_codes` is non-zero; strobes with all codes zero write nothing.
- R3: The crossing counter is cleared by the `acq_start` that enters acquisition. It increments on every strobe during acquisition, hit or not. An event records the value before that strobe's increment, so the first strobe after start is crossing 0.
- R4: At most 128 events are held. When the 128th is written, `mem_full` rises in the next cycle. Later hits are dropped, and `mem_full` stays high until the end-of-readout pulse.
- R5: The frame starts with the header: `chip_id`, MSB first. Then come the events, oldest first. Each event is the 24-bit crossing number MSB first, then channels 63 down to 0. Each channel is two bits, and channel i occupies `hit_codes[2i+1:2i]`, sent high bit first.
- R6: `rate_fast` is captured with `rd_req`. Each bit is held for FAST_DIV clocks if it was 1, or SLOW_DIV clocks if it was 0. The first header bit appears in the cycle after the request is taken.
- R7: `rd_done` is a one-cycle pulse that starts one bit period after the last bit begins. In the same step the memory empties and `mem_full` clears, so an immediate second readout sends only the header.
- R8: `rd_req` has no effect during acquisition. `acq_start`, `bx_strobe`, `hit_codes` and a change of `rate_fast` have no effect during readout.
- R9: `ser_out` is 0 whenever no readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_start | input | 1 | Begin acquisition (taken in idle) |
| acq_stop | input | 1 | End acquisition |
| bx_strobe | input | 1 | One pulse per bunch crossing |
| hit_codes | input | 128 | 2-bit code per channel, channel i at bits 2i+1:2i |
| rd_req | input | 1 | Start a serial readout (taken in idle) |
| rate_fast | input | 1 | 1 selects the fast bit rate, 0 the slow one |
| chip_id | input | 8 | Header value sent first |
| ser_out | output | 1 | Serial data |
| mem_full | output | 1 | All 128 event slots used |
| rd_done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The assertions assume that control pulses arrive in a sensible order. `rd_req` is only meaningful after `acq_stop`, and `hit_codes` is sampled only in a strobe cycle. They also assume that the reset is released before the first request. The stimulus drives every control input as a one-cycle pulse at the falling edge, and it always stops acquisition before requesting a readout. Some stimulus is deliberately out of place to exercise the ignore rules: requests during acquisition, and strobes, starts and rate changes during readout. This stimulus stays within those assumptions, because the design is specified to discard such inputs.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_HDR,
        ST_EVT,
        ST_DONE
    } hm_state_t;

    function automatic int hm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hm_bcid_ctr.sv
module hm_bcid_ctr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + W'(1);
        end
    end

endmodule

// File: rtl/hm_event_store.sv
module hm_event_store #(
    parameter int EVT_W = 152,
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [EVT_W-1:0] wr_data,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [EVT_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    logic [EVT_W-1:0] slots [DEPTH];
    logic             do_write;

    assign full     = (count == CNT_W'(DEPTH));
    assign do_write = wr_en && !full;
    assign rd_data  = slots[rd_idx];

    always_ff @(posedge clk) begin
        if (do_write) begin
            slots[count[IDX_W-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (do_write) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/hm_bit_timer.sv
module hm_bit_timer #(
    parameter int SLOW_DIV = 50,
    parameter int FAST_DIV = 10,
    localparam int MAX_DIV = hm_pkg::hm_max(SLOW_DIV, FAST_DIV),
    localparam int DIV_W   = $clog2(MAX_DIV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fast,
    output logic tick
);

    localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);
    localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = fast ? FAST_LIM : SLOW_LIM;
    assign tick = (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/hit_train_mem.sv
module hit_train_mem
    import hm_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int BCID_W   = 24,
    parameter int DEPTH    = 128,
    parameter int HDR_W    = 8,
    parameter int SLOW_DIV = 50,
    parameter int FAST_DIV = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acq_start,
    input  logic                  acq_stop,
    input  logic                  bx_strobe,
    input  logic [2*NUM_CH-1:0]   hit_codes,
    input  logic                  rd_req,
    input  logic                  rate_fast,
    input  logic [HDR_W-1:0]      chip_id,
    output logic                  ser_out,
    output logic                  mem_full,
    output logic                  rd_done
);

    localparam int CODES_W = 2 * NUM_CH;
    localparam int EVT_W   = BCID_W + CODES_W;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int BITS_W  = $clog2(EVT_W + 1);

    hm_state_t          state;
    hm_state_t          state_nx;

    logic [BCID_W-1:0]  bcid;
    logic [EVT_W-1:0]   shreg;
    logic [BITS_W-1:0]  bits_left;
    logic [CNT_W-1:0]   rd_ptr;
    logic               rate_q;

    logic [EVT_W-1:0]   rd_data;
    logic [CNT_W-1:0]   store_count;
    logic               store_full;
    logic               bit_tick;
    logic               busy;
    logic               any_hit;
    logic               last_bit;
    logic               more_events;
    logic               take_req;

    assign busy        = (state == ST_HDR) || (state == ST_EVT);
    assign any_hit     = |hit_codes;
    assign last_bit    = bit_tick && (bits_left == BITS_W'(1));
    assign more_events = (rd_ptr != store_count);
    assign take_req    = (state == ST_IDLE) && !acq_start && rd_req;

    hm_bcid_ctr #(
        .W(BCID_W)
    ) u_bcid (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state == ST_IDLE) && acq_start),
        .inc   ((state == ST_ACQ) && bx_strobe),
        .value (bcid)
    );

    hm_event_store #(
        .EVT_W (EVT_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   ((state == ST_ACQ) && bx_strobe && any_hit),
        .wr_data ({bcid, hit_codes}),
        .clr     (state == ST_DONE),
        .rd_idx  (rd_ptr[IDX_W-1:0]),
        .rd_data (rd_data),
        .count   (store_count),
        .full    (store_full)
    );

    hm_bit_timer #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!busy),
        .fast    (rate_q),
        .tick    (bit_tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (acq_start) begin
                    state_nx = ST_ACQ;
                end else if (rd_req) begin
                    state_nx = ST_HDR;
                end
            end
            ST_ACQ: begin
                if (acq_stop) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_HDR, ST_EVT: begin
                if (last_bit) begin
                    state_nx = more_events ? ST_EVT : ST_DONE;
                end
            end
            ST_DONE: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // serial datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            rd_ptr    <= '0;
            rate_q    <= 1'b0;
        end else if (take_req) begin
            shreg     <= {chip_id, {(EVT_W - HDR_W){1'b0}}};
            bits_left <= BITS_W'(HDR_W);
            rd_ptr    <= '0;
            rate_q    <= rate_fast;
        end else if (busy && bit_tick) begin
            if (last_bit && more_events) begin
                shreg     <= rd_data;
                bits_left <= BITS_W'(EVT_W);
                rd_ptr    <= rd_ptr + CNT_W'(1);
            end else begin
                shreg     <= {shreg[EVT_W-2:0], 1'b0};
                bits_left <= bits_left - BITS_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        ser_out  = 1'b0;
        rd_done  = 1'b0;
        mem_full = store_full;
        unique case (state)
            ST_HDR, ST_EVT: ser_out = shreg[EVT_W-1];
            ST_DONE:        rd_done = 1'b1;
            default:        ser_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/hm_checks.sv
module hm_checks
    import hm_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hm_state_t        state,
    input  logic             busy,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] count,
    input  logic             ser_out,
    input  logic             mem_full,
    input  logic             rd_done
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R4

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_full && !rd_done) |=> mem_full); // R4

    AST_NO_WRITE_AFTER_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || state == ST_IDLE) |=> $stable(count)); // R8

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> $stable(ser_out)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done); // R7

    AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (!mem_full && count == '0)); // R7

    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> $past(busy)); // R7

    AST_QUIET_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACQ) |=> (!ser_out || busy)); // R9

endmodule

bind hit_train_mem hm_checks #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_hm_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .busy     (busy),
    .bit_tick (bit_tick),
    .count    (store_count),
    .ser_out  (ser_out),
    .mem_full (mem_full),
    .rd_done  (rd_done)
);

// File: tb/test_hit_train_mem.sv
module test_hit_train_mem;

    localparam int NCH   = 64;
    localparam int CW    = 2 * NCH;
    localparam int BW    = 24;
    localparam int EW    = BW + CW;
    localparam int DEP   = 128;
    localparam int SDIV  = 5;
    localparam int FDIV  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_start = 1'b0;
    logic          acq_stop = 1'b0;
    logic          bx_strobe = 1'b0;
    logic [CW-1:0] hit_codes = '0;
    logic          rd_req = 1'b0;
    logic          rate_fast = 1'b0;
    logic [7:0]    chip_id = 8'hA5;
    logic          ser_out;
    logic          mem_full;
    logic          rd_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [EW-1:0] exp_evt [DEP];
    int            exp_n = 0;
    logic [BW-1:0] bcid_m = '0;

    always #10 clk = ~clk;

    hit_train_mem #(
        .SLOW_DIV (SDIV),
        .FAST_DIV (FDIV)
    ) i_hit_train_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .acq_start (acq_start),
        .acq_stop  (acq_stop),
        .bx_strobe (bx_strobe),
        .hit_codes (hit_codes),
        .rd_req    (rd_req),
        .rate_fast (rate_fast),
        .chip_id   (chip_id),
        .ser_out   (ser_out),
        .mem_full  (mem_full),
        .rd_done   (rd_done)
    );

    task automatic chk(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] rnd_codes(input int density);
        logic [CW-1:0] v = '0;
        for (int c = 0; c < NCH; c++) begin
            if ($urandom % density == 0) v[2*c +: 2] = 2'($urandom % 4);
        end
        return v;
    endfunction

    task automatic pulse_start();
        @(negedge clk) acq_start = 1'b1;
        @(posedge clk);
        @(negedge clk) acq_start = 1'b0;
        bcid_m = '0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) acq_stop = 1'b1;
        @(posedge clk);
        @(negedge clk) acq_stop = 1'b0;
    endtask

    task automatic strobe(input logic [CW-1:0] codes);
        @(negedge clk);
        bx_strobe = 1'b1;
        hit_codes = codes;
        @(posedge clk);
        if ((|codes) && exp_n < DEP) begin
            exp_evt[exp_n] = {bcid_m, codes};
            exp_n++;
        end
        bcid_m = bcid_m + 1'b1;
        @(negedge clk);
        bx_strobe = 1'b0;
        hit_codes = '0;
    endtask

    task automatic read_frame(input bit fast, input bit disturb, input string tag);
        int div = fast ? FDIV : SDIV;
        logic [EW-1:0] act;
        @(negedge clk);
        rate_fast = fast;
        rd_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_req = 1'b0;
        act = '0;
        for (int b = 0; b < 8; b++) begin
            act = {act[EW-2:0], ser_out};
            if (disturb && b == 2) begin
                acq_start = 1'b1;
                bx_strobe = 1'b1;
                hit_codes = '1;
                rate_fast = !fast;
                @(posedge clk);
                @(negedge clk);
                acq_start = 1'b0;
                bx_strobe = 1'b0;
                hit_codes = '0;
                repeat (div - 1) @(posedge clk);
                @(negedge clk);
            end else begin
                repeat (div) @(posedge clk);
                @(negedge clk);
            end
        end
        chk({"R5 R6 header ", tag}, act, {{(EW-8){1'b0}}, chip_id});
        for (int e = 0; e < exp_n; e++) begin
            act = '0;
            for (int b = 0; b < EW; b++) begin
                act = {act[EW-2:0], ser_out};
                repeat (div) @(posedge clk);
                @(negedge clk);
            end
            chk($sformatf("R3 R5 event %0d %s", e, tag), act, exp_evt[e]);
        end
        chk({"R7 done pulse ", tag}, EW'(rd_done), EW'(1));
        @(negedge clk);
        chk({"R7 R9 after done ", tag}, EW'({rd_done, ser_out, mem_full}), EW'(0));
        exp_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 reset outputs", EW'({ser_out, mem_full, rd_done}), EW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", EW'({ser_out, mem_full, rd_done}), EW'(0));

        // R2 only no-hit crossings: nothing stored
        pulse_start();
        for (int i = 0; i < 6; i++) strobe('0);
        pulse_stop();
        read_frame(1'b1, 1'b0, "no hits");

        // R2 R3 mixed random train, R8 request during acquisition
        chip_id = 8'h3C;
        pulse_start();
        for (int i = 0; i < 24; i++) begin
            if ($urandom % 3 == 0) strobe('0);
            else strobe(rnd_codes(1 + int'($urandom % 10)));
            if (i == 10) begin
                @(negedge clk) rd_req = 1'b1;
                @(posedge clk);
                @(negedge clk) rd_req = 1'b0;
                repeat (6) @(negedge clk);
                chk("R8 R9 request in acquisition", EW'({ser_out, rd_done}), EW'(0));
            end
        end
        strobe({2'b10, {(CW-4){1'b0}}, 2'b01});
        pulse_stop();
        read_frame(1'b1, 1'b0, "random fast");

        // R7 immediate second readout: header only
        read_frame(1'b1, 1'b0, "empty repeat");

        // R6 slow rate
        pulse_start();
        for (int i = 0; i < 5; i++) strobe(rnd_codes(4));
        pulse_stop();
        read_frame(1'b0, 1'b0, "slow rate");

        // R8 disturbance during readout; R6 rate held
        pulse_start();
        for (int i = 0; i < 3; i++) strobe(rnd_codes(2));
        pulse_stop();
        read_frame(1'b1, 1'b1, "disturbed");
        read_frame(1'b0, 1'b0, "after disturb");

        // R4 fill to capacity
        pulse_start();
        for (int i = 0; i < DEP - 1; i++) strobe(rnd_codes(16) | CW'(1));
        chk("R4 not full at 127", EW'(mem_full), EW'(0));
        strobe(rnd_codes(8) | CW'(2));
        chk("R4 full at 128", EW'(mem_full), EW'(1));
        for (int i = 0; i < 4; i++) strobe('1);
        strobe('0);
        chk("R4 full held", EW'(mem_full), EW'(1));
        pulse_stop();
        read_frame(1'b1, 1'b0, "full memory");
        chk("R4 R7 full cleared", EW'(mem_full), EW'(0));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule